// File: doc/BRIEF.md
# RAM Increment/Complement Device Tester

This block checks a RAM device. Each storage bit must be shown to hold a 0 and a 1. After a start request it runs two complete passes over the address space. In the first pass it writes a value derived from each address to every location. Only after all the writes are done does it read the locations back and compare them. The second pass does the same with the bitwise complement of those values. A read never follows the write to the same location at once. Because of this, a device that is absent from the bus cannot pass by echoing the charge left on the data lines. Because each location holds a distinct value, two addresses that share one cell also produce a mismatch.

The block is intended as the last stage of a bring-up sequence, after the data lines and address lines have been checked by other means. The caller raises `start` for one cycle and waits for the one-cycle `done` pulse. It then reads `pass`. On a failure, the first failing address, the value that was expected and the value that was returned are all held for diagnosis.

Top module: `mem_incr_tester`

## Requirements
- R1: In each fill pass the block writes addresses 0 to DEPTH-1 in ascending order, one write per clock cycle, where DEPTH = 2**ADDR_W.
- R2: In the first pass, address A receives (A+1) truncated to DATA_W bits. In the second pass, address A receives the bitwise complement of that value.
- R3: Within a pass, no read is issued until all DEPTH writes of that pass have been issued. `mem_we` and `mem_re` are never high together.
- R4: Reads sweep addresses 0 to DEPTH-1 in ascending order. The RAM returns read data one cycle after `mem_re`, and that data is compared with the value the current pass wrote to the same address.
- R5: On the first mismatch the block stops issuing accesses, drops `pass`, and latches the failing address, the expected value and the returned value. These outputs hold until the next accepted start.
- R6: A run in which every compare matches asserts `done` exactly 4*DEPTH+2 clock cycles after the edge that samples `start`, with `pass` = 1.
- R7: `done` is high for exactly one cycle per run. `busy` is high from the cycle after start is accepted up to and including the `done` cycle.
- R8: `start` has no effect while `busy` is high. The run in progress keeps its timing and result.
- R9: During and directly after reset, `busy`, `done`, `pass`, `mem_we`, `mem_re` and the three failure fields are all 0.
- R10: An accepted start clears `pass` and the failure fields to 0 for the duration of the new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run completed with no mismatch |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_re |
| fail_addr | output | ADDR_W | First failing address |
| fail_exp | output | DATA_W | Value expected at the failing address |
| fail_act | output | DATA_W | Value returned at the failing address |

## Verification
The assertions assume that the RAM answers every read with data exactly one cycle later. They also assume that `start` is a level the caller may raise at any time, including mid-run. The bench RAM model always uses the one-cycle read latency. It injects faults only into stored values or the address decode: cells stuck at 0 or 1, an aliased upper half, and an absent device that returns the last driven write value. It raises `start` both while idle and during a run, so the property that start is ignored while busy is exercised under the same input assumptions.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FILL1  = 3'd1,
    ST_CHECK1 = 3'd2,
    ST_FILL2  = 3'd3,
    ST_CHECK2 = 3'd4,
    ST_DONE   = 3'd5
  } mt_state_e;

  // Pattern for one location: address plus one, complemented in pass two.
  // Callers truncate the result to their data width (at most 32 bits).
  function automatic logic [31:0] mt_pattern(input logic [31:0] addr,
                                             input logic        inv);
    logic [31:0] v;
    v = addr + 32'd1;
    return inv ? ~v : v;
  endfunction

endpackage

// File: rtl/mtest_seq.sv
module mtest_seq
  import mtest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mismatch,
  output logic              start_ok,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] exp_data,
  output logic              fill_phase,
  output logic              chk_phase,
  output logic              wr_inv
);

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;
  localparam logic [CNT_W-1:0] LAST  = DEPTH - CNT_W'(1);

  mt_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FILL1;
            cnt_q   <= '0;
          end
        end
        ST_FILL1, ST_FILL2: begin
          if (cnt_q == LAST) begin
            state_q <= (state_q == ST_FILL1) ? ST_CHECK1 : ST_CHECK2;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_CHECK1, ST_CHECK2: begin
          if (mismatch) begin
            state_q <= ST_DONE;
          end else if (cnt_q == DEPTH) begin
            state_q <= (state_q == ST_CHECK1) ? ST_FILL2 : ST_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fill_phase = (state_q == ST_FILL1) || (state_q == ST_FILL2);
    chk_phase  = (state_q == ST_CHECK1) || (state_q == ST_CHECK2);
    wr_inv     = (state_q == ST_FILL2) || (state_q == ST_CHECK2);
    start_ok   = (state_q == ST_IDLE) && start;
    busy       = (state_q != ST_IDLE);
    done       = (state_q == ST_DONE);
    mem_addr   = cnt_q[ADDR_W-1:0];
    pat        = DATA_W'(mt_pattern(32'(mem_addr), wr_inv));
    mem_we     = fill_phase;
    mem_re     = chk_phase && !cnt_q[ADDR_W] && !mismatch;
    mem_wdata  = fill_phase ? pat : '0;
    exp_data   = pat;
  end

endmodule

// File: rtl/mtest_cmp.sv
module mtest_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue,
  input  logic              finish,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);

  logic              vld_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;

  assign mismatch = vld_q && !err_q && (rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      exp_q     <= '0;
      pass      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else begin
      vld_q  <= issue && !clear;
      addr_q <= rd_addr;
      exp_q  <= rd_exp;
      if (clear) begin
        err_q     <= 1'b0;
        pass      <= 1'b0;
        fail_addr <= '0;
        fail_exp  <= '0;
        fail_act  <= '0;
      end else if (mismatch) begin
        err_q     <= 1'b1;
        fail_addr <= addr_q;
        fail_exp  <= exp_q;
        fail_act  <= rdata;
      end else if (finish && !err_q) begin
        pass <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mem_incr_tester.sv
module mem_incr_tester #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);

  logic              start_ok;
  logic              mismatch;
  logic              fill_phase;
  logic              chk_phase;
  logic              wr_inv;
  logic [DATA_W-1:0] exp_data;

  mtest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mismatch   (mismatch),
    .start_ok   (start_ok),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .exp_data   (exp_data),
    .fill_phase (fill_phase),
    .chk_phase  (chk_phase),
    .wr_inv     (wr_inv)
  );

  mtest_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .issue     (mem_re),
    .finish    (done),
    .rd_addr   (mem_addr),
    .rd_exp    (exp_data),
    .rdata     (mem_rdata),
    .mismatch  (mismatch),
    .pass      (pass),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
  );

endmodule

// File: rtl/mtest_chk.sv
module mtest_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              fill_phase,
  input logic              wr_inv,
  input logic              mismatch,
  input logic [ADDR_W-1:0] fail_addr
);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R3

  AST_NO_READ_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_phase |-> !mem_re); // R3

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R1

  AST_WR_INV_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wr_inv) |-> (mem_wdata == ~DATA_W'(mem_addr + 1'b1))); // R2

  AST_MISMATCH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (!mem_re && !mem_we)); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |-> ($stable(fail_addr) && $stable(pass))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R8

endmodule

bind mem_incr_tester mtest_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .fill_phase (fill_phase),
  .wr_inv     (wr_inv),
  .mismatch   (mismatch),
  .fail_addr  (fail_addr)
);

// File: tb/mem_incr_tester_tb.sv
`timescale 1ns/1ps
module mem_incr_tester_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int RUN_CYC = 4 * DEPTH + 2;

  // Fault modes of the bench RAM
  localparam logic [2:0] M_GOOD = 3'd0, M_STK0 = 3'd1, M_STK1 = 3'd2,
                         M_ALIAS = 3'd3, M_ABSENT = 3'd4;

  // {mode, mask, expect_pass, fail_addr, fail_exp, fail_act}
  localparam logic [31:0] VEC [0:5] = '{
    {M_GOOD,   8'h00, 1'b1, 4'd0,  8'h00, 8'h00},
    {M_STK0,   8'h08, 1'b0, 4'd7,  8'h08, 8'h00},
    {M_STK1,   8'h01, 1'b0, 4'd1,  8'h02, 8'h03},
    {M_ALIAS,  8'h00, 1'b0, 4'd0,  8'h01, 8'h09},
    {M_ABSENT, 8'h00, 1'b0, 4'd0,  8'h01, 8'h10},
    {M_STK0,   8'h80, 1'b0, 4'd0,  8'hFE, 8'h7E}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, pass, mem_we, mem_re;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_act;

  int checks = 0;
  int failures = 0;
  int cyc_total = 0;

  logic [2:0]    f_mode = M_GOOD;
  logic [DW-1:0] f_mask = '0;
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] last_w = '0;
  int tw = 0;
  int tr = 0;

  always #2.5 clk = ~clk;

  mem_incr_tester #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // Bench RAM with one-cycle read latency and fault injection
  always_ff @(posedge clk) begin
    logic [AW-1:0] ix;
    ix = (f_mode == M_ALIAS) ? {1'b0, mem_addr[AW-2:0]} : mem_addr;
    if (mem_we) begin
      last_w <= mem_wdata;
      case (f_mode)
        M_STK0:  ram[ix] <= mem_wdata & ~f_mask;
        M_STK1:  ram[ix] <= mem_wdata | f_mask;
        default: ram[ix] <= mem_wdata;
      endcase
    end
    if (mem_re) mem_rdata <= (f_mode == M_ABSENT) ? last_w : ram[ix];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_val(input int a, input bit inv);
    logic [DW-1:0] v;
    v = DW'(a + 1);
    return inv ? ~v : v;
  endfunction

  // Bus monitor: write values/order, read ordering, no read before fill ends
  always @(negedge clk) begin
    if (rst_n && start && !busy) begin
      tw = 0;
      tr = 0;
    end else if (rst_n) begin
      if (mem_we) begin
        chk(mem_addr == AW'(tw % DEPTH), "R1", mem_addr, tw % DEPTH);
        chk(mem_wdata == ref_val(tw % DEPTH, tw >= DEPTH), "R2", mem_wdata,
            ref_val(tw % DEPTH, tw >= DEPTH));
        tw++;
      end
      if (mem_re) begin
        chk(tw == DEPTH * (tr / DEPTH + 1), "R3", tw, DEPTH * (tr / DEPTH + 1));
        chk(!mem_we, "R3", mem_we, 0);
        chk(mem_addr == AW'(tr % DEPTH), "R4", mem_addr, tr % DEPTH);
        tr++;
      end
    end
  end

  // Runs one test; returns cycles from the start edge to done.
  // poke_at: cycle at which start is raised again mid-run (0 = never).
  // clr_at: cycle at which cleared results are checked (0 = never).
  task automatic run(output int cyc, input int poke_at, input int clr_at);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (poke_at != 0 && cyc == poke_at) start = 1'b1;
      if (poke_at != 0 && cyc == poke_at + 1) start = 1'b0;
      if (clr_at != 0 && cyc == clr_at) begin
        chk(!pass && fail_addr == 0 && fail_exp == 0 && fail_act == 0, "R10",
            {pass, fail_addr, fail_exp, fail_act}, 0);
      end
      if (!done) chk(busy, "R7", busy, 1);
    end
    @(negedge clk);
    chk(!done, "R7", done, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc_total);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    int c;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !pass && !mem_we && !mem_re, "R9",
        {busy, done, pass, mem_we, mem_re}, 0);
    chk(fail_addr == 0 && fail_exp == 0 && fail_act == 0, "R9",
        {fail_addr, fail_exp, fail_act}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pass, "R9", {busy, pass}, 0);

    // Vector table: fault modes and expected results (R5, R6)
    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = VEC[i];
      f_mode = v[31:29];
      f_mask = v[28:21];
      run(c, 0, 0);
      chk(pass == v[20], "R5", pass, v[20]);
      if (v[20]) begin
        chk(c == RUN_CYC, "R6", c, RUN_CYC);
      end else begin
        chk(fail_addr == v[19:16], "R5", fail_addr, v[19:16]);
        chk(fail_exp == v[15:8], "R5", fail_exp, v[15:8]);
        chk(fail_act == v[7:0], "R5", fail_act, v[7:0]);
      end
      // Results hold while idle
      repeat (4) @(negedge clk);
      chk(pass == v[20] && (v[20] || fail_addr == v[19:16]), "R5",
          {pass, fail_addr}, {v[20], v[19:16]});
    end

    // R10: restart after a failure clears results, then passes
    f_mode = M_GOOD;
    f_mask = '0;
    run(c, 0, 5);
    chk(pass && c == RUN_CYC, "R10", c, RUN_CYC);

    // R8: start during a run is ignored
    run(c, 20, 0);
    chk(c == RUN_CYC && pass, "R8", c, RUN_CYC);
    repeat (3) @(negedge clk);
    chk(!busy, "R8", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule